// File: doc/BRIEF.md
# Dual Receive Frame Buffer

This block sits on the receive side of a small Ethernet MAC. It takes a byte stream that marks the first and last byte of each frame, packs the bytes into 32-bit words, and stores each frame in one of two equal buffers. A buffer that holds a finished frame is flagged as complete. It stays reserved until software clears that flag by writing the buffer's status word. The frame check sequence arrives as the last four bytes of the stream, and it is stored like any other byte.

Software sees one window of `2*BUF_BYTES` bytes. The first half is the first buffer and the second half is the second buffer. The last word of each half is that buffer's status word rather than frame storage. When `HAS_PONG` is 0, only the first buffer exists. Frames that find no free buffer are discarded and counted.

Top module: `rx_pingpong_buf`

## Requirements
- R1: After reset, both status words read 0, `irq` is 0 and `drop_count` is 0.
- R2: Byte k of a frame is stored at byte offset k of its buffer. Word offset 4j returns bytes 4j..4j+3, with byte 4j in bits 7:0. `rd_data` shows the word addressed by `host_addr` one clock after the address is applied.
- R3: With the default parameters, the first buffer occupies offsets 0x000-0x7FB and its status word is at 0x7FC. The second buffer occupies 0x800-0xFFB and its status word is at 0xFFC. In a status word, bit 0 is the frame-complete flag and bit 3 is the interrupt enable. All other bits read 0.
- R4: Every byte up to and including the end-of-frame byte is stored, so the four check bytes are kept. The complete flag reads 1 from the clock after the end-of-frame byte and holds until software clears it.
- R5: The first frame after reset goes to the first buffer. Each later frame goes to the buffer other than the one filled last, if that buffer's flag is clear. If that buffer is busy and the other is free, the frame goes to the free one.
- R6: A frame whose start byte finds every buffer flagged is discarded entirely and `drop_count` increases by 1. No buffer content and no flag changes.
- R7: A host write to a status word loads bit 3 into the interrupt enable. Bit 0 written as 0 clears the complete flag, and bit 0 written as 1 leaves the flag unchanged.
- R8: `irq` is 1 exactly when some buffer has both its complete flag and its interrupt enable set.
- R9: Bytes beyond `BUF_BYTES-4` are not stored, and neither the status word nor the start of the buffer is overwritten. The complete flag is still set at end of frame.
- R10: With `HAS_PONG` = 0, every frame uses the first buffer. A frame arriving while that buffer is flagged is dropped, and the second status word reads 0.
- R11: If a frame ends in the same cycle as a host write to that buffer's status word, the complete flag ends at 1 and the interrupt enable takes the written value.
- R12: Valid bytes that arrive outside a frame (no start byte since the last end or drop) are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| host_addr | input | $clog2(BUF_BYTES)+1 | Host byte address for reads and status writes |
| wr_en | input | 1 | Host write strobe (status words only) |
| wr_data | input | 32 | Host write data |
| rd_data | output | 32 | Registered host read data |
| irq | output | 1 | Frame-complete interrupt |
| drop_count | output | CNT_W | Count of frames discarded for lack of a buffer |

## Verification
Two events can land in the same cycle: completion of a frame and a host write to the same buffer's status word. The completion sets the flag and the host write may clear it. The bench aligns the end-of-frame byte with a write of 0 to that status word. It then expects the flag to read 1 and the interrupt enable to read 0. A second interaction is buffer choice: the bench releases only the buffer that was filled last and checks that the next frame falls back to it rather than being dropped.

// File: rtl/rx_pingpong_buf.sv
module rx_pingpong_buf #(
  parameter int BUF_BYTES = 2048,
  parameter int HAS_PONG  = 1,
  parameter int CNT_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [7:0]                   in_data,
  input  logic                         in_sof,
  input  logic                         in_eof,
  input  logic [$clog2(BUF_BYTES):0]   host_addr,
  input  logic                         wr_en,
  input  logic [31:0]                  wr_data,
  output logic [31:0]                  rd_data,
  output logic                         irq,
  output logic [CNT_W-1:0]             drop_count
);
  localparam int BUF_WORDS = BUF_BYTES / 4;
  localparam int WI_W      = $clog2(BUF_WORDS);
  localparam int PTR_W     = $clog2(BUF_BYTES) + 1;
  localparam int USE_BYTES = BUF_BYTES - 4;
  localparam bit TWO       = (HAS_PONG != 0);

  logic [31:0]      mem [2*BUF_WORDS];
  logic [1:0]       done, ie;
  logic             nxt, cur, active;
  logic [PTR_W-1:0] ptr;

  wire [1:0] avail = {TWO & ~done[1], ~done[0]};
  wire       pick  = avail[nxt] ? nxt : ~nxt;
  wire       sof_hit = in_valid & in_sof;
  wire       take  = sof_hit & (|avail);
  wire       inframe = take | (in_valid & ~in_sof & active);
  wire       wsel  = in_sof ? pick : cur;
  wire [PTR_W-1:0] wptr = in_sof ? '0 : ptr;
  wire       wr_byte = inframe & (wptr < PTR_W'(USE_BYTES));
  wire       fin   = inframe & in_eof;

  wire            hsel = host_addr[WI_W+2];
  wire [WI_W-1:0] hidx = host_addr[WI_W+1:2];
  wire            stat = &hidx;
  wire            hok  = ~hsel | TWO;
  wire            hwr  = wr_en & stat & hok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= '0;
      ie         <= '0;
      nxt        <= 1'b0;
      cur        <= 1'b0;
      active     <= 1'b0;
      ptr        <= '0;
      drop_count <= '0;
    end else begin
      if (hwr) begin
        done[hsel] <= done[hsel] & wr_data[0];
        ie[hsel]   <= wr_data[3];
      end
      if (sof_hit) begin
        if (|avail) begin
          cur    <= pick;
          active <= ~in_eof;
          ptr    <= PTR_W'(1);
        end else begin
          active     <= 1'b0;
          drop_count <= drop_count + 1'b1;
        end
      end else if (in_valid && active) begin
        if (ptr < PTR_W'(USE_BYTES)) ptr <= ptr + 1'b1;
        if (in_eof) active <= 1'b0;
      end
      if (fin) begin
        done[wsel] <= 1'b1;
        if (TWO) nxt <= ~wsel;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_byte) mem[{wsel, wptr[WI_W+1:2]}][8*wptr[1:0] +: 8] <= in_data;
    if (!hok)       rd_data <= '0;
    else if (stat)  rd_data <= {28'b0, ie[hsel], 2'b0, done[hsel]};
    else            rd_data <= mem[{hsel, hidx}];
  end

  assign irq = |(done & ie);
endmodule

module rx_pingpong_buf_chk #(
  parameter int HAS_PONG = 1,
  parameter int CNT_W    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic             in_eof,
  input logic             wr_en,
  input logic             irq,
  input logic [1:0]       done,
  input logic [CNT_W-1:0] drop_count
);
  assert_drop_only_on_sof_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_sof) |=> $stable(drop_count));

  assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && done[0] && (done[1] || HAS_PONG == 0))
      |=> drop_count == $past(drop_count) + 1'b1);

  assert_ping_set_by_eof_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done[0]) |-> $past(in_valid && in_eof));

  assert_pong_set_by_eof_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done[1]) |-> $past(in_valid && in_eof));

  assert_ping_clear_by_host_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done[0]) |-> $past(wr_en));

  assert_pong_clear_by_host_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done[1]) |-> $past(wr_en));

  assert_irq_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done != 2'b00));

  assert_single_buffer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_PONG == 0) |-> !done[1]);
endmodule

bind rx_pingpong_buf rx_pingpong_buf_chk #(.HAS_PONG(HAS_PONG), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
  .wr_en(wr_en), .irq(irq), .done(done), .drop_count(drop_count)
);

// File: tb/rx_pingpong_buf_tb.sv
module rx_pingpong_buf_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic s_valid = 0, s_sof = 0, s_eof = 0, sel_one = 0, h_wr = 0;
  logic [7:0] s_data = 0;
  logic [11:0] h_addr = 0;
  logic [31:0] h_wdata = 0;
  logic [31:0] rd0, rd1;
  logic irq0, irq1;
  logic [15:0] drop0, drop1;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rx_pingpong_buf u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid & ~sel_one), .in_data(s_data),
    .in_sof(s_sof), .in_eof(s_eof), .host_addr(h_addr), .wr_en(h_wr & ~sel_one),
    .wr_data(h_wdata), .rd_data(rd0), .irq(irq0), .drop_count(drop0));

  rx_pingpong_buf #(.HAS_PONG(0)) u_one (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid & sel_one), .in_data(s_data),
    .in_sof(s_sof), .in_eof(s_eof), .host_addr(h_addr), .wr_en(h_wr & sel_one),
    .wr_data(h_wdata), .rd_data(rd1), .irq(irq1), .drop_count(drop1));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(int n, int seed, bit no_sof);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      s_valid = 1; s_data = 8'(seed + k);
      s_sof = (k == 0) && !no_sof; s_eof = (k == n - 1);
    end
    @(negedge clk);
    s_valid = 0; s_sof = 0; s_eof = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    h_addr = a;
    @(negedge clk);
    v = sel_one ? rd1 : rd0;
  endtask

  task automatic hw(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    h_addr = a; h_wr = 1; h_wdata = d;
    @(negedge clk);
    h_wr = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h7FC, v); chk("R1 ping status", v, 0);
    rd(12'hFFC, v); chk("R1 pong status", v, 0);
    chk("R1 irq", irq0, 0);
    chk("R1 drop", drop0, 0);
  endtask

  task automatic t_pack_alt();
    logic [31:0] v;
    send(10, 8'h10, 0);
    rd(12'h7FC, v); chk("R4 ping done", v, 32'h1);
    rd(12'hFFC, v); chk("R3 pong status untouched", v, 0);
    rd(12'h000, v); chk("R2 word0 packing", v, 32'h13121110);
    rd(12'h008, v); chk("R4 last bytes kept", v[15:0], 16'h1918);
    send(6, 8'h40, 0);
    rd(12'hFFC, v); chk("R5 alternate to pong", v, 32'h1);
    rd(12'h800, v); chk("R3 pong data", v, 32'h43424140);
  endtask

  task automatic t_drop();
    logic [31:0] v;
    send(5, 8'h70, 0);
    chk("R6 drop count", drop0, 1);
    rd(12'h000, v); chk("R6 ping kept", v, 32'h13121110);
    rd(12'h800, v); chk("R6 pong kept", v, 32'h43424140);
  endtask

  task automatic t_host();
    logic [31:0] v;
    hw(12'h7FC, 32'h8);
    rd(12'h7FC, v); chk("R7 clear with ie", v, 32'h8);
    chk("R8 irq off", irq0, 0);
    hw(12'hFFC, 32'h9);
    rd(12'hFFC, v); chk("R7 write one keeps flag", v, 32'h9);
    chk("R8 irq on", irq0, 1);
    hw(12'hFFC, 32'h0);
    rd(12'hFFC, v); chk("R7 pong cleared", v, 0);
    chk("R8 irq off again", irq0, 0);
  endtask

  task automatic t_fallback();
    logic [31:0] v;
    send(8, 8'h60, 0);
    chk("R8 irq from ping", irq0, 1);
    send(8, 8'h80, 0);
    rd(12'hFFC, v); chk("R5 E to pong", v, 32'h1);
    hw(12'hFFC, 32'h0);
    send(8, 8'hA0, 0);
    rd(12'hFFC, v); chk("R5 fallback flag", v, 32'h1);
    rd(12'h800, v); chk("R5 fallback data", v, 32'hA3A2A1A0);
    rd(12'h000, v); chk("R5 ping kept", v, 32'h63626160);
  endtask

  task automatic t_stray();
    logic [31:0] v;
    hw(12'h7FC, 32'h8);
    hw(12'hFFC, 32'h0);
    send(4, 8'hAA, 1);
    rd(12'h7FC, v); chk("R12 stray no ping flag", v, 32'h8);
    rd(12'hFFC, v); chk("R12 stray no pong flag", v, 0);
    rd(12'h000, v); chk("R12 ping data kept", v, 32'h63626160);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      s_valid = 1; s_data = 8'(8'hC0 + k); s_sof = (k == 0); s_eof = 0;
    end
    @(negedge clk);
    s_data = 8'hC3; s_sof = 0; s_eof = 1;
    h_addr = 12'h7FC; h_wr = 1; h_wdata = 32'h0;
    @(negedge clk);
    s_valid = 0; s_eof = 0; h_wr = 0;
    rd(12'h7FC, v); chk("R11 set wins, ie loaded", v, 32'h1);
    chk("R11 irq follows ie", irq0, 0);
    rd(12'h000, v); chk("R11 data", v, 32'hC3C2C1C0);
  endtask

  task automatic t_trunc();
    logic [31:0] v;
    hw(12'h7FC, 32'h0);
    send(2060, 0, 0);
    rd(12'hFFC, v); chk("R9 flag set, status clean", v, 32'h1);
    rd(12'h800, v); chk("R9 start not overwritten", v, 32'h03020100);
    rd(12'hFF8, v); chk("R9 last stored word", v, 32'hFBFAF9F8);
  endtask

  task automatic t_single();
    logic [31:0] v;
    sel_one = 1;
    send(4, 8'h21, 0);
    rd(12'h7FC, v); chk("R10 ping done", v, 32'h1);
    send(4, 8'h31, 0);
    chk("R10 second frame dropped", drop1, 1);
    rd(12'hFFC, v); chk("R10 pong absent", v, 0);
    rd(12'h000, v); chk("R10 ping data", v, 32'h24232221);
    sel_one = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pack_alt();
    t_drop();
    t_host();
    t_fallback();
    t_stray();
    t_collide();
    t_trunc();
    t_single();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule